// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block sits between the encoded interrupt request lines of the peripherals and the processor core's sequencer. Peripherals present a 3-bit priority level, where zero means nothing is pending. Each time the core signals that an instruction has just finished, the arbiter compares the filtered level against the 3-bit interrupt mask that lives in the status register. It decides in that cycle whether the core must take the interrupt.

When a request is taken, the mask is overwritten with the serviced level, and the block runs an acknowledge cycle. During that cycle it drives the level on the low address lines, with every other address line high. The device being serviced may answer with an 8-bit vector number on the data lines. If it does not answer within a fixed window, the block supplies an automatic vector instead. Software can load the mask directly through a write port. A build-time option restricts the block to recognising only levels 2, 5 and 7.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset the mask reads 7, and take_o, ack_strobe_o and vec_valid_o are low, with ack_addr_o zero.
- R2: A request is evaluated only in a cycle where insn_done_i is high; with insn_done_i low, no level ever produces take_o.
- R3: A filtered level L from 1 to 6 is taken only when L is strictly greater than the mask. Equal or lower levels, and level 0, are not taken and stay pending.
- R4: Level 7 is taken whatever the mask value, including a mask of 7.
- R5: On acceptance, take_o is high for exactly one cycle, the cycle after the evaluating edge. From that same cycle mask_o equals the accepted level.
- R6: While ack_strobe_o is high, ack_addr_o[2:0] carries the serviced level and every higher address bit is 1. While ack_strobe_o is low, ack_addr_o is all zeros.
- R7: If ack_valid_i is high at an edge during the acknowledge, ack_data_i is captured. The cycle after that edge, vec_valid_o pulses with vec_num_o equal to the captured byte, and ack_strobe_o drops.
- R8: If no vector arrives, ack_strobe_o stays high for ACK_TIMEOUT cycles (default 8). The acknowledge then ends with vec_valid_o and vec_num_o = 24 + level.
- R9: The level on irq_level_i must be equal in two consecutive clock samples before it is compared. A level held for a single cycle is never taken, and a steady level can be taken no earlier than the third edge after it appears.
- R10: While an acknowledge is in progress, insn_done_i and new requests are ignored and take_o stays low.
- R11: A pulse on mask_wr_i loads mask_wr_data_i into the mask, visible on mask_o the next cycle. If an acceptance happens at the same edge, the accepted level wins.
- R12: With REDUCED = 1, only levels 2, 5 and 7 are recognised, and any other nonzero level is treated as no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level_i | input | 3 | Encoded request level, 0 = none |
| insn_done_i | input | 1 | Instruction boundary strobe from the core |
| mask_wr_i | input | 1 | Load the mask from mask_wr_data_i |
| mask_wr_data_i | input | 3 | New mask value |
| ack_valid_i | input | 1 | Device has placed a vector on ack_data_i |
| ack_data_i | input | 8 | Vector number from the device |
| take_o | output | 1 | One-cycle pulse: interrupt accepted |
| mask_o | output | 3 | Current interrupt mask (status bits 10:8) |
| ack_strobe_o | output | 1 | Acknowledge cycle in progress |
| ack_addr_o | output | ADDR_W | Acknowledge address: level in bits 2:0, rest high |
| vec_valid_o | output | 1 | One-cycle pulse: vec_num_o is valid |
| vec_num_o | output | 8 | Device-supplied or automatic vector number |

## Verification
The bench pins the strict comparison by offering levels equal to and below the mask. A design using greater-or-equal would take the equal level. It drives level 7 against a mask of 7, which a design that masked the top level would drop. It also holds insn_done_i high through an acknowledge, which a design that did not lock out new requests would answer with a second take. A one-cycle glitch and the exact three-edge latency of a steady level expose a missing or misaligned input filter. A silent device exposes a wrong timeout length or a wrong automatic vector base. A second instance in reduced mode must ignore levels 3 and 6 even when they lie above the mask.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_ACK  = 1'b1
    } arb_phase_e;

    localparam logic [2:0] LVL_NONE     = 3'd0;
    localparam logic [2:0] LVL_NMI      = 3'd7;
    localparam logic [2:0] MASK_RESET   = 3'd7;
    localparam logic [7:0] AUTOVEC_BASE = 8'd24;

endpackage

// File: rtl/irq_level_filter.sv
module irq_level_filter #(
    parameter bit REDUCED = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] raw_lvl_i,
    output logic [2:0] lvl_o
);
    import irq_arb_pkg::*;

    typedef struct packed {
        logic [2:0] smp;
        logic [2:0] stb;
    } filt_regs_t;

    filt_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.smp = raw_lvl_i;
        if (raw_lvl_i == r_q.smp) begin
            r_d.stb = raw_lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    generate
        if (REDUCED) begin : g_reduced
            always_comb begin
                case (r_q.stb)
                    3'd2, 3'd5, 3'd7: lvl_o = r_q.stb;
                    default:          lvl_o = LVL_NONE;
                endcase
            end
        end else begin : g_full
            assign lvl_o = r_q.stb;
        end
    endgenerate

endmodule

// File: rtl/irq_priority_check.sv
module irq_priority_check (
    input  logic       eval_en_i,
    input  logic [2:0] req_lvl_i,
    input  logic [2:0] mask_i,
    output logic       grant_o
);
    import irq_arb_pkg::*;

    logic above_mask;
    logic is_nmi;

    always_comb begin
        above_mask = (req_lvl_i > mask_i);
        is_nmi     = (req_lvl_i == LVL_NMI);
        grant_o    = eval_en_i && (req_lvl_i != LVL_NONE) && (above_mask || is_nmi);
    end

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned ACK_TIMEOUT = 8,
    parameter bit          REDUCED     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        irq_level_i,
    input  logic              insn_done_i,
    input  logic              mask_wr_i,
    input  logic [2:0]        mask_wr_data_i,
    input  logic              ack_valid_i,
    input  logic [7:0]        ack_data_i,
    output logic              take_o,
    output logic [2:0]        mask_o,
    output logic              ack_strobe_o,
    output logic [ADDR_W-1:0] ack_addr_o,
    output logic              vec_valid_o,
    output logic [7:0]        vec_num_o
);
    import irq_arb_pkg::*;

    localparam int unsigned CNT_W = $clog2(ACK_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_TIMEOUT - 1);
    localparam int unsigned HI_W = ADDR_W - 3;

    typedef struct packed {
        arb_phase_e       phase;
        logic [2:0]       mask;
        logic [2:0]       lvl;
        logic [CNT_W-1:0] cnt;
        logic             take;
        logic             vec_vld;
        logic [7:0]       vec;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [2:0] filt_lvl;
    logic       grant;
    logic       eval_en;

    irq_level_filter #(
        .REDUCED (REDUCED)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_lvl_i (irq_level_i),
        .lvl_o     (filt_lvl)
    );

    assign eval_en = insn_done_i && (r_q.phase == PH_IDLE);

    irq_priority_check u_prio (
        .eval_en_i (eval_en),
        .req_lvl_i (filt_lvl),
        .mask_i    (r_q.mask),
        .grant_o   (grant)
    );

    always_comb begin
        r_d         = r_q;
        r_d.take    = 1'b0;
        r_d.vec_vld = 1'b0;
        if (mask_wr_i) begin
            r_d.mask = mask_wr_data_i;
        end
        case (r_q.phase)
            PH_IDLE: begin
                if (grant) begin
                    r_d.phase = PH_ACK;
                    r_d.mask  = filt_lvl;
                    r_d.lvl   = filt_lvl;
                    r_d.cnt   = '0;
                    r_d.take  = 1'b1;
                end
            end
            PH_ACK: begin
                if (ack_valid_i) begin
                    r_d.vec     = ack_data_i;
                    r_d.vec_vld = 1'b1;
                    r_d.phase   = PH_IDLE;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.vec     = AUTOVEC_BASE + {5'd0, r_q.lvl};
                    r_d.vec_vld = 1'b1;
                    r_d.phase   = PH_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.phase   <= PH_IDLE;
            r_q.mask    <= MASK_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        take_o       = r_q.take;
        mask_o       = r_q.mask;
        ack_strobe_o = (r_q.phase == PH_ACK);
        ack_addr_o   = ack_strobe_o ? {{HI_W{1'b1}}, r_q.lvl} : '0;
        vec_valid_o  = r_q.vec_vld;
        vec_num_o    = r_q.vec;
    end

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
    parameter int unsigned ADDR_W  = 24,
    parameter bit          REDUCED = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done_i,
    input logic              take_o,
    input logic [2:0]        mask_o,
    input logic              ack_strobe_o,
    input logic [ADDR_W-1:0] ack_addr_o,
    input logic              vec_valid_o
);

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(insn_done_i)); // R2

    AST_TAKE_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (mask_o > $past(mask_o)) || (mask_o == 3'd7)); // R3

    AST_NMI_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ($past(mask_o) == 3'd7)) |-> (mask_o == 3'd7)); // R4

    AST_TAKE_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (ack_strobe_o && (ack_addr_o[2:0] == mask_o))); // R5

    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R5

    AST_ACK_ADDR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe_o |-> (ack_addr_o[ADDR_W-1:3] == '1)); // R6

    AST_ACK_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_strobe_o |-> (ack_addr_o == '0)); // R6

    AST_VEC_ENDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> ($past(ack_strobe_o) && !ack_strobe_o)); // R7

    AST_NO_TAKE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(ack_strobe_o)); // R10

    AST_REDUCED_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && REDUCED) |-> (mask_o == 3'd2 || mask_o == 3'd5 || mask_o == 3'd7)); // R12

endmodule

bind irq_level_arbiter irq_arb_checker #(
    .ADDR_W  (ADDR_W),
    .REDUCED (REDUCED)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_done_i  (insn_done_i),
    .take_o       (take_o),
    .mask_o       (mask_o),
    .ack_strobe_o (ack_strobe_o),
    .ack_addr_o   (ack_addr_o),
    .vec_valid_o  (vec_valid_o)
);

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;

    localparam int ADDR_W = 24;
    localparam int TMO    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq = 3'd0;
    logic        done = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  wdata = 3'd0;
    logic        avld = 1'b0;
    logic [7:0]  adata = 8'd0;
    logic        take, strobe, vvld;
    logic [2:0]  mask;
    logic [ADDR_W-1:0] addr;
    logic [7:0]  vnum;

    logic [2:0]  r_irq = 3'd0;
    logic        r_done = 1'b0;
    logic        r_wr = 1'b0;
    logic [2:0]  r_wdata = 3'd0;
    logic        r_take, r_strobe, r_vvld;
    logic [2:0]  r_mask;
    logic [ADDR_W-1:0] r_addr;
    logic [7:0]  r_vnum;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_level_arbiter #(.ADDR_W(ADDR_W), .ACK_TIMEOUT(TMO), .REDUCED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_level_i(irq), .insn_done_i(done),
        .mask_wr_i(wr), .mask_wr_data_i(wdata), .ack_valid_i(avld), .ack_data_i(adata),
        .take_o(take), .mask_o(mask), .ack_strobe_o(strobe), .ack_addr_o(addr),
        .vec_valid_o(vvld), .vec_num_o(vnum));

    irq_level_arbiter #(.ADDR_W(ADDR_W), .ACK_TIMEOUT(TMO), .REDUCED(1'b1)) u_red (
        .clk(clk), .rst_n(rst_n), .irq_level_i(r_irq), .insn_done_i(r_done),
        .mask_wr_i(r_wr), .mask_wr_data_i(r_wdata), .ack_valid_i(1'b0), .ack_data_i(8'd0),
        .take_o(r_take), .mask_o(r_mask), .ack_strobe_o(r_strobe), .ack_addr_o(r_addr),
        .vec_valid_o(r_vvld), .vec_num_o(r_vnum));

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_lvl(input logic [2:0] l);
        @(negedge clk) irq = l;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk) done = 1'b0;
    endtask

    task automatic wr_mask(input logic [2:0] m);
        @(negedge clk) begin wr = 1'b1; wdata = m; end
        @(negedge clk) wr = 1'b0;
        check("R11 mask write", mask, m);
    endtask

    task automatic give_vec(input logic [7:0] v);
        avld = 1'b1; adata = v;
        @(negedge clk) avld = 1'b0;
        check("R7 vec valid", vvld, 1);
        check("R7 vec num", vnum, v);
        check("R7 strobe drops", strobe, 0);
    endtask

    task automatic t_reset();
        check("R1 mask", mask, 7);
        check("R1 take", take, 0);
        check("R1 strobe", strobe, 0);
        check("R1 addr", addr, 0);
        check("R1 vvld", vvld, 0);
    endtask

    task automatic t_compare();
        wr_mask(3'd3);
        set_lvl(3'd3); pulse_done();
        check("R3 equal level not taken", take, 0);
        set_lvl(3'd2); pulse_done();
        check("R3 lower level not taken", take, 0);
        set_lvl(3'd0); pulse_done();
        check("R3 level 0 not taken", take, 0);
        set_lvl(3'd4); pulse_done();
        check("R3 higher level taken", take, 1);
        check("R5 mask set to level", mask, 4);
        check("R6 strobe", strobe, 1);
        check("R6 ack addr", addr, 24'hFFFFF8 | 24'd4);
        @(negedge clk);
        check("R5 take one cycle", take, 0);
        give_vec(8'h40);
        check("R6 addr idle", addr, 0);
        pulse_done();
        check("R3 pending equal not retaken", take, 0);
        set_lvl(3'd0);
    endtask

    task automatic t_boundary_and_timeout();
        int cnt;
        wr_mask(3'd0);
        set_lvl(3'd6);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (take) cnt++;
        end
        check("R2 no take without boundary", cnt, 0);
        pulse_done();
        check("R2 take at boundary", take, 1);
        cnt = 1;
        for (int i = 0; i < 50 && strobe; i++) begin
            @(negedge clk);
            if (strobe) cnt++;
        end
        check("R8 strobe length", cnt, TMO);
        check("R8 autovector valid", vvld, 1);
        check("R8 autovector number", vnum, 24 + 6);
        set_lvl(3'd0);
    endtask

    task automatic t_nmi_and_busy();
        int cnt;
        wr_mask(3'd7);
        set_lvl(3'd7); pulse_done();
        check("R4 level 7 over mask 7", take, 1);
        check("R4 mask", mask, 7);
        done = 1'b1;
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (take) cnt++;
        end
        done = 1'b0;
        check("R10 no take during ack", cnt, 0);
        check("R10 still acking", strobe, 1);
        give_vec(8'h91);
        set_lvl(3'd0);
    endtask

    task automatic t_filter();
        int cnt;
        wr_mask(3'd0);
        done = 1'b1;
        irq = 3'd5;
        @(negedge clk) irq = 3'd0;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (take) cnt++;
        end
        check("R9 glitch ignored", cnt, 0);
        irq = 3'd3;
        @(negedge clk) check("R9 no take after 1 edge", take, 0);
        @(negedge clk) check("R9 no take after 2 edges", take, 0);
        @(negedge clk) check("R9 take after 3 edges", take, 1);
        done = 1'b0;
        give_vec(8'h55);
        set_lvl(3'd0);
    endtask

    task automatic t_reduced();
        int cnt;
        @(negedge clk) begin r_wr = 1'b1; r_wdata = 3'd0; end
        @(negedge clk) r_wr = 1'b0;
        check("R11 reduced mask write", r_mask, 0);
        r_irq = 3'd3; repeat (2) @(negedge clk);
        r_done = 1'b1; @(negedge clk) r_done = 1'b0;
        check("R12 level 3 ignored", r_take, 0);
        r_irq = 3'd5; repeat (2) @(negedge clk);
        r_done = 1'b1; @(negedge clk) r_done = 1'b0;
        check("R12 level 5 taken", r_take, 1);
        check("R12 mask 5", r_mask, 5);
        cnt = 0;
        for (int i = 0; i < 50 && !r_vvld; i++) @(negedge clk);
        check("R8 reduced autovector", r_vnum, 29);
        r_irq = 3'd6; repeat (2) @(negedge clk);
        r_done = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (r_take) cnt++;
        end
        r_done = 1'b0;
        check("R12 level 6 ignored above mask", cnt, 0);
        r_irq = 3'd0;
    endtask

    task automatic t_write_collision();
        wr_mask(3'd1);
        set_lvl(3'd5);
        done = 1'b1; wr = 1'b1; wdata = 3'd2;
        @(negedge clk) begin done = 1'b0; wr = 1'b0; end
        check("R11 accept wins over write", mask, 5);
        check("R11 take", take, 1);
        give_vec(8'h12);
        set_lvl(3'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compare();
        t_boundary_and_timeout();
        t_nmi_and_busy();
        t_filter();
        t_reduced();
        t_write_collision();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule